// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block moves outgoing frames for one channel. It reads a ring of two-word descriptors from a shared memory through a simple request/acknowledge port and gathers one or more fragments into a frame. It removes trailing pad bytes as the last descriptor of the frame specifies, then sends the frame one byte per cycle on a stream with start and end markers. When a frame is finished, the engine writes zero into word 0 of the frame's first descriptor to give it back. It then pulses a transmit interrupt request.

Work starts on a one-cycle `kick` while `tx_en` is high. One pass sends a bounded burst of frames. A pass ends early at the first descriptor the engine does not own. The ring position carries over from one pass to the next. Descriptor `i` sits at word address `ring_base + 2*i`, and the index returns to 0 after `ring_len-1`. A frame whose trimmed length exceeds the limit is not sent. Its descriptor is still released, and `tx_drop` pulses in place of the interrupt.

Top module: `txr_engine`

## Requirements
- R1: When the engine reads a descriptor whose word 0 bit 31 (ownership) is clear, the pass ends at once. Nothing is sent, nothing is written, and the next pass starts from that same descriptor.
- R2: Descriptor word 0 bits 15:0 hold the fragment length in bytes, word 0 bit 30 marks the frame's last fragment, and word 1 holds the buffer word address. The fragments of a frame are sent in ring order, and the bytes of each buffer word are taken least-significant byte first.
- R3: The frame length is the sum of the fragment lengths minus ((4 - pad) mod 4), where pad is bits 23:22 of word 0 of the frame's last descriptor. Pad codes 0, 1, 2 and 3 therefore remove 0, 3, 2 and 1 bytes.
- R4: After a frame, the engine writes 0x00000000 to word 0 of the frame's first descriptor only. The other descriptors of the frame are not written.
- R5: `tx_irq` is a one-cycle pulse, one per released frame that was sent, issued the cycle after the release write is acknowledged.
- R6: One pass sends at most BURST (default 16) frames. The next pass continues with the following descriptor.
- R7: A frame whose trimmed length exceeds MAXLEN (default 18000) bytes sends no bytes. It is still released, `tx_drop` pulses once, and `tx_irq` stays low.
- R8: While `tx_en` is low, a `kick` is ignored and descriptors are neither read nor written.
- R9: After descriptor `ring_len-1`, the engine continues at descriptor 0. A frame may span the wrap.
- R10: `out_sof` marks the first byte and `out_eof` the last byte of each frame sent. Both are only high together with `out_valid`.
- R11: Once `mem_req` is raised, it stays high with a stable address until `mem_ack` is seen.
- R12: After reset all outputs are low and the ring position is descriptor 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Channel transmit enable |
| kick | input | 1 | Start a ring scan pass |
| ring_base | input | AW | Word address of descriptor 0 |
| ring_len | input | IW | Number of descriptors in the ring |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access done; read data valid |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Output byte valid |
| out_byte | output | 8 | Output byte |
| out_sof | output | 1 | First byte of frame |
| out_eof | output | 1 | Last byte of frame |
| tx_irq | output | 1 | Frame sent and released |
| tx_drop | output | 1 | Oversized frame discarded |

## Verification
Each memory access takes two cycles with the bench's memory model: the acknowledge comes one cycle after the request. A byte appears on the stream the cycle after the engine selects its lane, and `tx_irq` or `tx_drop` follows the acknowledged release write by one cycle. Because these latencies add up over descriptor reads, the bench compares frame-level results rather than cycle numbers. It lets a settle window much longer than the longest pass elapse after each `kick`. It then compares the bytes, markers, pulses and descriptor words that monitors collected on the falling clock edge against values computed from the requirements.

// File: rtl/txr_pkg.sv
// Shared definitions for the transmit descriptor ring engine.
// Assumes descriptors are two 32-bit words: control word, then buffer address.
package txr_pkg;
    localparam int OWN_BIT = 31;   // engine may process the descriptor
    localparam int END_BIT = 30;   // last fragment of the frame
    localparam int PAD_LO  = 22;   // 2-bit pad code at [23:22]
    localparam int LEN_W   = 16;   // fragment length field width

    typedef enum logic [3:0] {
        S_IDLE, S_SCAN, S_CHECK, S_HDR, S_BUF, S_DATA, S_EMIT, S_NEXT, S_REL
    } txr_state_e;
endpackage

// File: rtl/txr_ring_step.sv
// Computes the ring index that follows idx, returning to 0 after ring_len-1.
// Assumes ring_len is at least 1.
module txr_ring_step #(
    parameter int IW = 8
) (
    input  logic [IW-1:0] idx,
    input  logic [IW-1:0] ring_len,
    output logic [IW-1:0] nxt
);
    // wrap or increment
    assign nxt = (idx == ring_len - 1'b1) ? '0 : idx + 1'b1;
endmodule

// File: rtl/txr_len_calc.sv
// Turns a summed fragment length and a pad code into the sent length,
// and flags frames above the length limit. Clamps at zero.
module txr_len_calc #(
    parameter int SW     = 24,
    parameter int MAXLEN = 18000
) (
    input  logic [SW-1:0] sum,
    input  logic [1:0]    pad,
    output logic [SW-1:0] flen,
    output logic          over
);
    logic [1:0] trim;
    // bytes removed: (4 - pad) mod 4 equals (-pad) mod 4
    assign trim = 2'd0 - pad;
    // trimmed length
    assign flen = (sum > SW'(trim)) ? sum - SW'(trim) : '0;
    // limit test
    assign over = flen > SW'(MAXLEN);
endmodule

// File: rtl/txr_lane.sv
// Selects one byte of a 32-bit word; lane 0 is the least significant byte.
module txr_lane (
    input  logic [31:0] word,
    input  logic [1:0]  sel,
    output logic [7:0]  lane_byte
);
    // byte lane mux
    assign lane_byte = word[{sel, 3'b000} +: 8];
endmodule

// File: rtl/txr_engine.sv
// Transmit descriptor ring engine for one channel.
// Walks a descriptor ring twice per frame: a scan pass sums lengths and finds
// the last fragment, a send pass streams bytes. Then it releases the first
// descriptor and signals completion. Assumes the memory holds mem_rdata valid
// while mem_ack is high, and that the ring holds a frame end before wrapping
// onto the frame's own first descriptor.
module txr_engine #(
    parameter int AW     = 16,
    parameter int IW     = 8,
    parameter int MAXLEN = 18000,
    parameter int BURST  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_en,
    input  logic          kick,
    input  logic [AW-1:0] ring_base,
    input  logic [IW-1:0] ring_len,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          out_valid,
    output logic [7:0]    out_byte,
    output logic          out_sof,
    output logic          out_eof,
    output logic          tx_irq,
    output logic          tx_drop
);
    import txr_pkg::*;

    localparam int SW = LEN_W + IW;
    localparam int CW = $clog2(BURST + 1);

    txr_state_e          st_q;
    logic [IW-1:0]       head_q, cur_q, last_q;
    logic [SW-1:0]       sum_q, left_q;
    logic [LEN_W-1:0]    frag_q;
    logic [1:0]          pad_q, lane_q;
    logic [AW-1:0]       buf_q;
    logic [31:0]         word_q;
    logic [CW-1:0]       cnt_q;
    logic                first_q, drop_q;

    logic [IW-1:0]       cur_nxt, last_nxt;
    logic [SW-1:0]       flen;
    logic                over;
    logic [7:0]          lane_byte;
    logic [AW-1:0]       cur_addr, head_addr;
    logic [LEN_W-1:0]    rd_len;

    txr_ring_step #(.IW(IW)) u_step_cur  (.idx(cur_q),  .ring_len(ring_len), .nxt(cur_nxt));
    txr_ring_step #(.IW(IW)) u_step_last (.idx(last_q), .ring_len(ring_len), .nxt(last_nxt));
    txr_len_calc  #(.SW(SW), .MAXLEN(MAXLEN)) u_len (.sum(sum_q), .pad(pad_q), .flen(flen), .over(over));
    txr_lane u_lane (.word(word_q), .sel(lane_q), .lane_byte(lane_byte));

    assign cur_addr  = ring_base + AW'({cur_q, 1'b0});
    assign head_addr = ring_base + AW'({head_q, 1'b0});
    assign rd_len    = mem_rdata[LEN_W-1:0];

    // memory request decode from the current state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_addr;
        mem_wdata = '0;
        unique case (st_q)
            S_SCAN, S_HDR: mem_req = 1'b1;
            S_BUF:  begin mem_req = 1'b1; mem_addr = cur_addr + 1'b1; end
            S_DATA: begin mem_req = 1'b1; mem_addr = buf_q; end
            S_REL:  begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = head_addr; end
            default: ;
        endcase
    end

    // control sequencer: scan, length check, send, release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= S_IDLE;  head_q <= '0;  cur_q <= '0;  last_q <= '0;
            sum_q <= '0;  left_q <= '0;  frag_q <= '0;  pad_q <= '0;
            lane_q <= '0;  buf_q <= '0;  word_q <= '0;  cnt_q <= '0;
            first_q <= 1'b0;  drop_q <= 1'b0;
            out_valid <= 1'b0;  out_byte <= '0;  out_sof <= 1'b0;  out_eof <= 1'b0;
            tx_irq <= 1'b0;  tx_drop <= 1'b0;
        end else begin
            out_valid <= 1'b0;  out_sof <= 1'b0;  out_eof <= 1'b0;
            tx_irq <= 1'b0;  tx_drop <= 1'b0;
            unique case (st_q)
                S_IDLE: if (kick && tx_en) begin
                    cur_q <= head_q;  sum_q <= '0;  cnt_q <= '0;  st_q <= S_SCAN;
                end
                S_SCAN: if (mem_ack) begin
                    if (!mem_rdata[OWN_BIT]) begin
                        st_q <= S_IDLE;
                    end else begin
                        sum_q <= sum_q + SW'(rd_len);
                        if (mem_rdata[END_BIT]) begin
                            last_q <= cur_q;
                            pad_q  <= mem_rdata[PAD_LO +: 2];
                            st_q   <= S_CHECK;
                        end else begin
                            cur_q <= cur_nxt;
                        end
                    end
                end
                S_CHECK: begin
                    drop_q  <= over;
                    tx_drop <= over;
                    left_q  <= flen;
                    cur_q   <= head_q;
                    first_q <= 1'b1;
                    st_q    <= (over || flen == '0) ? S_REL : S_HDR;
                end
                S_HDR: if (mem_ack) begin
                    frag_q <= rd_len;  st_q <= S_BUF;
                end
                S_BUF: if (mem_ack) begin
                    buf_q <= mem_rdata[AW-1:0];
                    st_q  <= (frag_q == '0) ? S_NEXT : S_DATA;
                end
                S_DATA: if (mem_ack) begin
                    word_q <= mem_rdata;  lane_q <= '0;  st_q <= S_EMIT;
                end
                S_EMIT: begin
                    out_valid <= 1'b1;
                    out_byte  <= lane_byte;
                    out_sof   <= first_q;
                    out_eof   <= (left_q == SW'(1));
                    first_q   <= 1'b0;
                    left_q    <= left_q - 1'b1;
                    frag_q    <= frag_q - 1'b1;
                    lane_q    <= lane_q + 1'b1;
                    if (left_q == SW'(1))           st_q <= S_REL;
                    else if (frag_q == LEN_W'(1))   st_q <= S_NEXT;
                    else if (lane_q == 2'd3) begin
                        buf_q <= buf_q + 1'b1;  st_q <= S_DATA;
                    end
                end
                S_NEXT: begin
                    cur_q <= cur_nxt;  st_q <= S_HDR;
                end
                S_REL: if (mem_ack) begin
                    tx_irq <= !drop_q;
                    head_q <= last_nxt;
                    cur_q  <= last_nxt;
                    sum_q  <= '0;
                    cnt_q  <= cnt_q + 1'b1;
                    st_q   <= (cnt_q + 1'b1 == CW'(BURST) || !tx_en) ? S_IDLE : S_SCAN;
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    // byte count of the frame on the stream, for the length assertion
    logic [SW-1:0] seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n)         seen_q <= '0;
        else if (out_valid) seen_q <= out_sof ? SW'(1) : seen_q + 1'b1;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));                        // R11
    AST_IRQ_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> $past(mem_req && mem_we && mem_ack && mem_wdata == '0));           // R5
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_irq, tx_drop}));                                                 // R7
    AST_FRAME_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_eof && !out_sof |-> seen_q + 1'b1 <= SW'(MAXLEN));           // R7
    AST_MARK_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sof || out_eof) |-> out_valid);                                          // R10
    AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(BURST));                                                         // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(st_q == S_IDLE && !tx_en) |-> !mem_req);                                // R8
endmodule

// File: tb/test_txr_engine.sv
module test_txr_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0, kick = 1'b0;
    logic [15:0] ring_base = 16'h0010;
    logic [7:0]  ring_len = 8'd8;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata = '0;
    logic        out_valid, out_sof, out_eof, tx_irq, tx_drop;
    logic [7:0]  out_byte;

    always #5 clk = ~clk;

    txr_engine i_txr_engine (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .kick(kick),
        .ring_base(ring_base), .ring_len(ring_len),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_byte(out_byte), .out_sof(out_sof),
        .out_eof(out_eof), .tx_irq(tx_irq), .tx_drop(tx_drop)
    );

    logic [31:0] mem [0:1023];
    int nchk = 0, nfail = 0;
    int nbytes = 0, nsof = 0, neof = 0, nirq = 0, ndrop = 0, hs_bad = 0;
    logic [7:0] cap [0:4095];
    logic last_req = 1'b0, last_ack = 1'b0;

    // memory model: acknowledge one cycle after a request
    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[9:0]];
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // output and handshake monitor on the falling edge
    always @(negedge clk) begin
        if (out_valid) begin
            cap[nbytes] <= out_byte;
            nbytes <= nbytes + 1;
        end
        if (out_sof) nsof <= nsof + 1;
        if (out_eof) neof <= neof + 1;
        if (tx_irq)  nirq <= nirq + 1;
        if (tx_drop) ndrop <= ndrop + 1;
        if (last_req && !last_ack && !mem_req) hs_bad <= hs_bad + 1;
        last_req <= mem_req;
        last_ack <= mem_ack;
    end

    function automatic logic [7:0] bexp(int a, int k);
        return 8'((a * 4 + k) * 13 + 7);
    endfunction

    function automatic logic [31:0] dw0(bit own, bit last, int pad, int len);
        return {own, last, 6'b0, 2'(pad), 6'b0, 16'(len)};
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_desc(int idx, logic [31:0] w0, int bufa);
        mem[ring_base + 2 * idx] = w0;
        mem[ring_base + 2 * idx + 1] = 32'(bufa);
    endtask

    function automatic logic [31:0] desc_w0(int idx);
        return mem[ring_base + 2 * idx];
    endfunction

    task automatic pass_run(int settle);
        @(negedge clk) kick = 1'b1;
        @(negedge clk) kick = 1'b0;
        repeat (settle) @(negedge clk);
    endtask

    task automatic check_bytes(int at, int a, int n, string req);
        for (int i = 0; i < n; i++)
            chk(cap[at + i] == bexp(a + i / 4, i % 4), req, cap[at + i], bexp(a + i / 4, i % 4));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R12: outputs after reset
    task automatic t_reset();
        do_reset();
        chk(!mem_req && !out_valid && !out_sof && !out_eof && !tx_irq && !tx_drop,
            "R12 outputs low", {mem_req, out_valid, tx_irq, tx_drop}, 0);
    endtask

    // R2 R4 R5 R10: single-fragment frame, no trim
    task automatic t_single();
        int b0 = nbytes, i0 = nirq, s0 = nsof, e0 = neof;
        set_desc(0, dw0(1, 1, 0, 6), 'h200);
        set_desc(1, '0, 0);
        pass_run(300);
        chk(nbytes - b0 == 6, "R2 byte count", nbytes - b0, 6);
        check_bytes(b0, 'h200, 6, "R2 data");
        chk(nsof - s0 == 1 && neof - e0 == 1, "R10 markers", nsof - s0, 1);
        chk(nirq - i0 == 1, "R5 irq pulse", nirq - i0, 1);
        chk(desc_w0(0) == 0, "R4 release", desc_w0(0), 0);
    endtask

    // R3 R2 R4: two fragments, pad code 2 removes two bytes
    task automatic t_frag_pad2();
        int b0 = nbytes;
        set_desc(1, dw0(1, 0, 0, 5), 'h210);
        set_desc(2, dw0(1, 1, 2, 4), 'h220);
        set_desc(3, '0, 0);
        pass_run(300);
        chk(nbytes - b0 == 7, "R3 pad2 length", nbytes - b0, 7);
        check_bytes(b0, 'h210, 5, "R2 frag one");
        check_bytes(b0 + 5, 'h220, 2, "R3 frag two trimmed");
        chk(desc_w0(1) == 0, "R4 first released", desc_w0(1), 0);
        chk(desc_w0(2) == dw0(1, 1, 2, 4), "R4 later untouched", desc_w0(2), dw0(1, 1, 2, 4));
    endtask

    // R3: pad codes 1 and 3
    task automatic t_pad13();
        int b0 = nbytes, i0 = nirq, e0 = neof;
        set_desc(3, dw0(1, 1, 1, 8), 'h230);
        set_desc(4, dw0(1, 1, 3, 8), 'h240);
        set_desc(5, '0, 0);
        pass_run(400);
        chk(nbytes - b0 == 12, "R3 pad1+pad3 length", nbytes - b0, 12);
        check_bytes(b0, 'h230, 5, "R3 pad1 data");
        check_bytes(b0 + 5, 'h240, 7, "R3 pad3 data");
        chk(nirq - i0 == 2 && neof - e0 == 2, "R5 two frames", nirq - i0, 2);
    endtask

    // R8: kick ignored while disabled; R1 then stop at unowned
    task automatic t_disabled();
        int b0 = nbytes, i0 = nirq;
        set_desc(5, dw0(1, 1, 0, 3), 'h250);
        set_desc(6, '0, 0);
        tx_en = 1'b0;
        pass_run(200);
        chk(nbytes == b0 && nirq == i0, "R8 no output while disabled", nbytes - b0, 0);
        chk(desc_w0(5) == dw0(1, 1, 0, 3), "R8 descriptor untouched", desc_w0(5), dw0(1, 1, 0, 3));
        tx_en = 1'b1;
        pass_run(300);
        check_bytes(b0, 'h250, 3, "R8 sent after enable");
        chk(nbytes - b0 == 3, "R1 pass stops at unowned", nbytes - b0, 3);
        b0 = nbytes; i0 = nirq;
        pass_run(200);
        chk(nbytes == b0 && nirq == i0, "R1 unowned sends nothing", nbytes - b0, 0);
    endtask

    // R9: frame spans the wrap; R1 pass resumed from the unowned slot
    task automatic t_wrap();
        int b0 = nbytes, i0 = nirq;
        set_desc(6, dw0(1, 1, 0, 2), 'h260);
        set_desc(7, dw0(1, 0, 0, 3), 'h270);
        set_desc(0, dw0(1, 1, 0, 1), 'h280);
        set_desc(1, '0, 0);
        pass_run(400);
        chk(nbytes - b0 == 6, "R9 bytes across wrap", nbytes - b0, 6);
        check_bytes(b0, 'h260, 2, "R1 resumed at unowned slot");
        check_bytes(b0 + 2, 'h270, 3, "R9 before wrap");
        check_bytes(b0 + 5, 'h280, 1, "R9 after wrap");
        chk(nirq - i0 == 2, "R9 irq count", nirq - i0, 2);
        chk(desc_w0(7) == 0, "R9 release first of wrapped frame", desc_w0(7), 0);
    endtask

    // R7: oversized frame is dropped but released
    task automatic t_drop();
        int b0 = nbytes, i0 = nirq, d0 = ndrop;
        set_desc(1, dw0(1, 0, 0, 9001), 'h290);
        set_desc(2, dw0(1, 1, 0, 9001), 'h290);
        set_desc(3, '0, 0);
        pass_run(200);
        chk(nbytes == b0, "R7 no bytes", nbytes - b0, 0);
        chk(ndrop - d0 == 1, "R7 drop pulse", ndrop - d0, 1);
        chk(nirq == i0, "R7 no irq", nirq - i0, 0);
        chk(desc_w0(1) == 0, "R7 released", desc_w0(1), 0);
    endtask

    // R6: burst bound per pass on a fresh 20-entry ring
    task automatic t_burst();
        int b0, i0;
        ring_base = 16'h0040;
        ring_len = 8'd20;
        do_reset();
        for (int i = 0; i < 20; i++) set_desc(i, dw0(1, 1, 0, 1), 'h300);
        b0 = nbytes; i0 = nirq;
        pass_run(800);
        chk(nirq - i0 == 16, "R6 frames in first pass", nirq - i0, 16);
        chk(desc_w0(16) == dw0(1, 1, 0, 1), "R6 seventeenth still owned", desc_w0(16), dw0(1, 1, 0, 1));
        chk(desc_w0(15) == 0, "R6 sixteenth released", desc_w0(15), 0);
        i0 = nirq;
        pass_run(400);
        chk(nirq - i0 == 4, "R6 remaining frames", nirq - i0, 4);
        chk(nbytes - b0 == 20, "R6 total bytes", nbytes - b0, 20);
    endtask

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        for (int a = 0; a < 1024; a++)
            mem[a] = {bexp(a, 3), bexp(a, 2), bexp(a, 1), bexp(a, 0)};
        t_reset();
        tx_en = 1'b1;
        t_single();
        t_frag_pad2();
        t_pad13();
        t_disabled();
        t_wrap();
        t_drop();
        t_burst();
        chk(hs_bad == 0, "R11 request held until ack", hs_bad, 0);
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule